// File: doc/BRIEF.md
# Alias-Checking Virtually Indexed Cache Tag Lookup

This block is the tag side of a two-way set-associative cache whose set index is taken from the virtual address before translation. Pages are 4 KB, so address bits [11:0] are the same in the virtual and the physical address. The index field is bits [13:6], so its two top bits, [13:12], are translated bits. Their physical value may differ from the virtual one. The same physical line can therefore sit in any of four sets that share index bits [11:6]. Each tag stores the full physical page number (bits [31:12]). This lets the block identify a line wherever it sits among those four sets.

A lookup takes two stages. In the cycle a request is accepted, the valid bits, dirty bits, tags and LRU bits of all four candidate sets are captured. In a later cycle the translation unit presents the physical page number, and all eight tags are compared against it together. A match in the home set (the set named by the virtual index) is a hit. No match is a miss. A match in one of the other three sets is an alias. In that case the block invalidates the stray copy, asks for a writeback when the copy is dirty, and refills the line into the home set.

Data arrays, the translation unit and the next cache level sit outside the block. They are reached through a plain translation strobe and two valid/ready request channels. A request channel's valid stays high, with a stable address, until ready is seen high at a clock edge. The lookup input is valid/ready as well: it is ready only while no lookup is in flight.

Top module: `vic_alias_lookup`

## Requirements
- R1: After reset every line is invalid, so the first lookup of any address reports a miss. After reset `req_ready` is 1 and `res_valid`, `wb_valid` and `fill_valid` are 0.
- R2: A lookup is accepted at a clock edge where `req_valid` and `req_ready` are both 1. Its result appears, with `res_valid` = 1, during the first later cycle in which `xlat_valid` is 1. `req_ready` stays 0 from acceptance until the lookup is finished.
- R3: A valid tag equal to `xlat_ppn` in the home set {VA[13:12], VA[11:6]} gives `res_kind` = 2'b00 with `res_way` set to the matching way. A hit issues no writeback or refill, and the block is ready again in the next cycle.
- R4: When no candidate set matches, `res_kind` = 2'b01 and `res_way` names the victim way. One refill is requested at `fill_addr` = {ppn, VA[11:6], 6'b0}. When that refill is accepted, the victim way is written valid and clean with the new tag.
- R5: A valid match in a candidate set other than the home set gives `res_kind` = 2'b10. If two such copies exist, the lowest set wins, and within a set the lower way wins. The stray copy is invalidated, and the line is refilled into the victim way of the home set.
- R6: An alias whose stray copy is dirty issues one writeback at {ppn, VA[11:6], 6'b0} before the refill. A clean stray copy issues no writeback.
- R7: A hit with `req_write` = 1 marks the line dirty. A refill always leaves the line clean.
- R8: Each set holds one LRU bit. A hit or a refill makes the other way the next victim. A victim that is valid and dirty is written back at {old tag, VA[11:6], 6'b0} before the refill, after any alias writeback.
- R9: `wb_valid` and `fill_valid` are held with a stable address until the matching ready is seen at a clock edge. `req_ready` stays 0 until the refill handshake completes.
- R10: `res_kind` never takes the value 2'b11, and `res_valid` is 1 only while `xlat_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_vindex | input | 8 | Virtual index bits VA[13:6] |
| req_write | input | 1 | Lookup is a store (marks the line dirty on a hit) |
| xlat_valid | input | 1 | Physical page number is valid this cycle |
| xlat_ppn | input | 20 | Physical page number, PA[31:12] |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 00 hit, 01 miss, 10 alias |
| res_way | output | 1 | Hit way, or the way chosen for the refill |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request accepted |
| wb_addr | output | 32 | Physical line address to write back |
| fill_valid | output | 1 | Refill request valid |
| fill_ready | input | 1 | Refill accepted; the tag is installed |
| fill_addr | output | 32 | Physical line address to refill |

## Verification
Most internal faults appear first at the ports, within one or two lookups. A dirty bit that is never set hides the writeback owed on the next alias or eviction. A wrong LRU bit moves the refill to the other way, which `res_way` reports at once. A comparison that ignores the candidate sets turns an alias into a miss in the same cycle the result is issued. The reference model in the bench replays every lookup, so a corrupted tag also shows up later as a wrong hit/miss/alias class or a wrong writeback address. The handshake monitors also flag a request issued while the block claims to be ready.

// File: rtl/vic_alias_pkg.sv
`timescale 1ns/1ps
package vic_alias_pkg;
  typedef enum logic [1:0] {
    RES_HIT   = 2'b00,
    RES_MISS  = 2'b01,
    RES_ALIAS = 2'b10
  } res_kind_e;

  typedef enum logic [1:0] {
    OP_TOUCH    = 2'b00,
    OP_TOUCH_WR = 2'b01,
    OP_INVAL    = 2'b10,
    OP_FILL     = 2'b11
  } tag_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB_ALIAS,
    ST_WB_VICT,
    ST_FILL
  } lookup_st_e;
endpackage

// File: rtl/vic_tag_store.sv
`timescale 1ns/1ps
module vic_tag_store
  import vic_alias_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int XL_W  = 2,
  parameter int TAG_W = 20
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [SET_W-XL_W-1:0]                 rd_low,
  output logic [(1<<XL_W)-1:0][1:0]             rd_valid,
  output logic [(1<<XL_W)-1:0][1:0]             rd_dirty,
  output logic [(1<<XL_W)-1:0][1:0][TAG_W-1:0]  rd_tag,
  output logic [(1<<XL_W)-1:0]                  rd_lru,
  input  logic                                  wr_en,
  input  tag_op_e                               wr_op,
  input  logic [SET_W-1:0]                      wr_set,
  input  logic                                  wr_way,
  input  logic [TAG_W-1:0]                      wr_tag
);
  localparam int SETS  = 1 << SET_W;
  localparam int CANDS = 1 << XL_W;

  logic [SETS-1:0][1:0] valid_q;
  logic [SETS-1:0][1:0] dirty_q;
  logic [SETS-1:0]      lru_q;
  logic [TAG_W-1:0]     tag_q [SETS][2];

  // Read all candidate sets that share the untranslated index bits.
  for (genvar c = 0; c < CANDS; c++) begin : g_cand
    localparam logic [XL_W-1:0] CI = XL_W'(c);
    logic [SET_W-1:0] cset;
    assign cset        = {CI, rd_low};
    assign rd_valid[c] = valid_q[cset];
    assign rd_dirty[c] = dirty_q[cset];
    assign rd_lru[c]   = lru_q[cset];
    for (genvar w = 0; w < 2; w++) begin : g_way
      assign rd_tag[c][w] = tag_q[cset][w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      lru_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_op)
        OP_TOUCH: lru_q[wr_set] <= ~wr_way;
        OP_TOUCH_WR: begin
          lru_q[wr_set]           <= ~wr_way;
          dirty_q[wr_set][wr_way] <= 1'b1;
        end
        OP_INVAL: begin
          valid_q[wr_set][wr_way] <= 1'b0;
          dirty_q[wr_set][wr_way] <= 1'b0;
        end
        OP_FILL: begin
          valid_q[wr_set][wr_way] <= 1'b1;
          dirty_q[wr_set][wr_way] <= 1'b0;
          lru_q[wr_set]           <= ~wr_way;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_op == OP_FILL) tag_q[wr_set][wr_way] <= wr_tag;
  end
endmodule

// File: rtl/vic_alias_match.sv
`timescale 1ns/1ps
module vic_alias_match #(
  parameter int XL_W  = 2,
  parameter int TAG_W = 20
) (
  input  logic [(1<<XL_W)-1:0][1:0]             cand_valid,
  input  logic [(1<<XL_W)-1:0][1:0][TAG_W-1:0]  cand_tag,
  input  logic [XL_W-1:0]                       home,
  input  logic [TAG_W-1:0]                      ppn,
  output logic                                  hit,
  output logic                                  hit_way,
  output logic                                  alias_found,
  output logic [XL_W-1:0]                       alias_cand,
  output logic                                  alias_way
);
  localparam int CANDS = 1 << XL_W;

  logic [CANDS-1:0][1:0] match;

  for (genvar c = 0; c < CANDS; c++) begin : g_c
    for (genvar w = 0; w < 2; w++) begin : g_w
      assign match[c][w] = cand_valid[c][w] && (cand_tag[c][w] == ppn);
    end
  end

  // Home-set match is a hit; the first match elsewhere is an alias.
  always_comb begin
    hit         = 1'b0;
    hit_way     = 1'b0;
    alias_found = 1'b0;
    alias_cand  = '0;
    alias_way   = 1'b0;
    for (int c = 0; c < CANDS; c++) begin
      for (int w = 0; w < 2; w++) begin
        if (match[c][w]) begin
          if (XL_W'(c) == home) begin
            if (!hit) begin
              hit     = 1'b1;
              hit_way = w[0];
            end
          end else if (!alias_found) begin
            alias_found = 1'b1;
            alias_cand  = XL_W'(c);
            alias_way   = w[0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/vic_alias_lookup.sv
`timescale 1ns/1ps
module vic_alias_lookup
  import vic_alias_pkg::*;
#(
  parameter int PA_W     = 32,
  parameter int PAGE_LSB = 12,
  parameter int IDX_LSB  = 6,
  parameter int IDX_MSB  = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [IDX_MSB-IDX_LSB:0]    req_vindex,
  input  logic                        req_write,
  input  logic                        xlat_valid,
  input  logic [PA_W-PAGE_LSB-1:0]    xlat_ppn,
  output logic                        res_valid,
  output logic [1:0]                  res_kind,
  output logic                        res_way,
  output logic                        wb_valid,
  input  logic                        wb_ready,
  output logic [PA_W-1:0]             wb_addr,
  output logic                        fill_valid,
  input  logic                        fill_ready,
  output logic [PA_W-1:0]             fill_addr
);
  localparam int TAG_W = PA_W - PAGE_LSB;
  localparam int SET_W = IDX_MSB - IDX_LSB + 1;
  localparam int XL_W  = IDX_MSB + 1 - PAGE_LSB;
  localparam int LOW_W = PAGE_LSB - IDX_LSB;
  localparam int CANDS = 1 << XL_W;

  lookup_st_e st_q, st_d;

  logic [LOW_W-1:0]                  low_q;
  logic [XL_W-1:0]                   home_q;
  logic                              wr_q;
  logic [TAG_W-1:0]                  ppn_q;
  logic [CANDS-1:0][1:0]             snap_v_q, snap_d_q;
  logic [CANDS-1:0][1:0][TAG_W-1:0]  snap_t_q;
  logic [CANDS-1:0]                  snap_l_q;
  logic                              fill_way_q;
  logic                              vict_wb_q;
  logic [PA_W-1:0]                   vict_addr_q;

  logic [CANDS-1:0][1:0]             rd_v, rd_d;
  logic [CANDS-1:0][1:0][TAG_W-1:0]  rd_t;
  logic [CANDS-1:0]                  rd_l;

  logic            m_hit, m_hit_way, m_alias, m_alias_way;
  logic [XL_W-1:0] m_alias_cand;

  logic            wr_en;
  tag_op_e         wr_op;
  logic [SET_W-1:0] wr_set;
  logic            wr_way;

  logic accept, cmp_go, victim, vict_dirty, alias_dirty;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmp_go    = (st_q == ST_CMP) && xlat_valid;

  vic_tag_store #(.SET_W(SET_W), .XL_W(XL_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_low   (req_vindex[LOW_W-1:0]),
    .rd_valid (rd_v),
    .rd_dirty (rd_d),
    .rd_tag   (rd_t),
    .rd_lru   (rd_l),
    .wr_en    (wr_en),
    .wr_op    (wr_op),
    .wr_set   (wr_set),
    .wr_way   (wr_way),
    .wr_tag   (ppn_q)
  );

  vic_alias_match #(.XL_W(XL_W), .TAG_W(TAG_W)) u_match (
    .cand_valid  (snap_v_q),
    .cand_tag    (snap_t_q),
    .home        (home_q),
    .ppn         (xlat_ppn),
    .hit         (m_hit),
    .hit_way     (m_hit_way),
    .alias_found (m_alias),
    .alias_cand  (m_alias_cand),
    .alias_way   (m_alias_way)
  );

  assign victim      = snap_l_q[home_q];
  assign vict_dirty  = snap_v_q[home_q][victim] && snap_d_q[home_q][victim];
  assign alias_dirty = snap_d_q[m_alias_cand][m_alias_way];

  // Result strobe and class
  assign res_valid = cmp_go;
  always_comb begin
    if (m_hit)        res_kind = RES_HIT;
    else if (m_alias) res_kind = RES_ALIAS;
    else              res_kind = RES_MISS;
  end
  assign res_way = m_hit ? m_hit_way : victim;

  // Outgoing request channels
  assign wb_valid   = (st_q == ST_WB_ALIAS) || (st_q == ST_WB_VICT);
  assign wb_addr    = (st_q == ST_WB_ALIAS) ? {ppn_q, low_q, {IDX_LSB{1'b0}}} : vict_addr_q;
  assign fill_valid = (st_q == ST_FILL);
  assign fill_addr  = {ppn_q, low_q, {IDX_LSB{1'b0}}};

  // Single tag-store write port
  always_comb begin
    wr_en  = 1'b0;
    wr_op  = OP_TOUCH;
    wr_set = {home_q, low_q};
    wr_way = fill_way_q;
    if (cmp_go && m_hit) begin
      wr_en  = 1'b1;
      wr_op  = wr_q ? OP_TOUCH_WR : OP_TOUCH;
      wr_way = m_hit_way;
    end else if (cmp_go && m_alias) begin
      wr_en  = 1'b1;
      wr_op  = OP_INVAL;
      wr_set = {m_alias_cand, low_q};
      wr_way = m_alias_way;
    end else if (fill_valid && fill_ready) begin
      wr_en  = 1'b1;
      wr_op  = OP_FILL;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_CMP;
      ST_CMP: begin
        if (cmp_go) begin
          if (m_hit)                      st_d = ST_IDLE;
          else if (m_alias && alias_dirty) st_d = ST_WB_ALIAS;
          else if (vict_dirty)            st_d = ST_WB_VICT;
          else                            st_d = ST_FILL;
        end
      end
      ST_WB_ALIAS: if (wb_ready) st_d = vict_wb_q ? ST_WB_VICT : ST_FILL;
      ST_WB_VICT:  if (wb_ready) st_d = ST_FILL;
      ST_FILL:     if (fill_ready) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // Stage 1 snapshot and stage 2 bookkeeping
  always_ff @(posedge clk) begin
    if (accept) begin
      low_q    <= req_vindex[LOW_W-1:0];
      home_q   <= req_vindex[SET_W-1:LOW_W];
      wr_q     <= req_write;
      snap_v_q <= rd_v;
      snap_d_q <= rd_d;
      snap_t_q <= rd_t;
      snap_l_q <= rd_l;
    end
    if (cmp_go) begin
      ppn_q       <= xlat_ppn;
      fill_way_q  <= victim;
      vict_wb_q   <= vict_dirty;
      vict_addr_q <= {snap_t_q[home_q][victim], low_q, {IDX_LSB{1'b0}}};
    end
  end
endmodule

// File: rtl/vic_alias_chk.sv
`timescale 1ns/1ps
module vic_alias_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            xlat_valid,
  input logic            res_valid,
  input logic [1:0]      res_kind,
  input logic            wb_valid,
  input logic            wb_ready,
  input logic [PA_W-1:0] wb_addr,
  input logic            fill_valid,
  input logic            fill_ready,
  input logic [PA_W-1:0] fill_addr
);
  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_addr));
  // R9
  stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wb_valid && !fill_valid && !res_valid);
  // R10
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_kind != 2'b11);
  // R10
  res_needs_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> xlat_valid);
  // R3
  hit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'b00 |=> req_ready);
  // R2
  miss_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind != 2'b00 |=> !req_ready);
  // R9
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && fill_valid));
endmodule

bind vic_alias_lookup vic_alias_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/vic_alias_lookup_bench.sv
`timescale 1ns/1ps
module vic_alias_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vindex = '0;
  logic        req_write = 1'b0;
  logic        xlat_valid = 1'b0;
  logic [19:0] xlat_ppn = '0;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic        res_way;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [31:0] wb_addr;
  logic        fill_valid;
  logic        fill_ready = 1'b0;
  logic [31:0] fill_addr;

  always #2.5 clk = ~clk;

  vic_alias_lookup u_vic_alias_lookup (.*);

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  typedef struct { logic [1:0] kind; logic way; } res_t;
  res_t        res_q[$];
  logic [31:0] wb_q[$];
  logic [31:0] fill_q[$];

  // Reference model of the tag state, built from the requirements
  logic        mv [256][2];
  logic        md [256][2];
  logic [19:0] mt [256][2];
  logic        ml [256];

  int wb_lat = 0, fill_lat = 0, xl_lat = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] nxt();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // Driver: predicts, pushes expectations, drives one lookup
  task automatic access(input logic [7:0] vi, input logic [19:0] pn, input bit wr);
    logic [5:0] low;
    logic [1:0] home;
    bit hit, al;
    int hw, ac, aw;
    logic v;
    res_t r;
    low = vi[5:0];
    home = vi[7:6];
    hit = 0; al = 0; hw = 0; ac = 0; aw = 0;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 2; w++)
        if (mv[{c[1:0], low}][w] && mt[{c[1:0], low}][w] == pn) begin
          if (c[1:0] == home) begin
            if (!hit) begin hit = 1; hw = w; end
          end else if (!al) begin
            al = 1; ac = c; aw = w;
          end
        end
    if (hit) begin
      r.kind = 2'b00; r.way = hw[0];
      if (wr) md[vi][hw] = 1;
      ml[vi] = ~hw[0];
    end else begin
      v = ml[vi];
      r.kind = al ? 2'b10 : 2'b01; r.way = v;
      if (al) begin
        if (md[{ac[1:0], low}][aw]) wb_q.push_back({pn, low, 6'b0});
        mv[{ac[1:0], low}][aw] = 0;
        md[{ac[1:0], low}][aw] = 0;
      end
      if (mv[vi][v] && md[vi][v]) wb_q.push_back({mt[vi][v], low, 6'b0});
      fill_q.push_back({pn, low, 6'b0});
      mv[vi][v] = 1; md[vi][v] = 0; mt[vi][v] = pn; ml[vi] = ~v;
    end
    while (!req_ready) step();
    req_valid = 1; req_vindex = vi; req_write = wr;
    step();
    req_valid = 0;
    check(req_ready == 1'b0, "R2 ready low after accept", {31'b0, req_ready}, 32'h0);
    repeat (xl_lat) step();
    res_q.push_back(r);
    xlat_valid = 1; xlat_ppn = pn;
    step();
    xlat_valid = 0;
    while (!req_ready) step();
  endtask

  // Monitors (sample on the falling edge)
  initial forever begin
    @(negedge clk);
    if (rst_n && res_valid) begin
      if (res_q.size() == 0) check(0, "R2 unexpected result", {30'b0, res_kind}, 32'hFFFF_FFFF);
      else begin
        res_t e;
        e = res_q.pop_front();
        check(res_kind == e.kind, e.kind == 2'b00 ? "R3 kind" : (e.kind == 2'b01 ? "R4 kind" : "R5 kind"),
              {30'b0, res_kind}, {30'b0, e.kind});
        check(res_way == e.way, "R8 res_way", {31'b0, res_way}, {31'b0, e.way});
      end
    end
    if (rst_n && wb_valid && wb_ready) begin
      check(!req_ready, "R9 ready during writeback", {31'b0, req_ready}, 32'h0);
      if (wb_q.size() == 0) check(0, "R6 unexpected writeback", wb_addr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        e = wb_q.pop_front();
        check(wb_addr == e, "R6 R8 writeback address", wb_addr, e);
      end
    end
    if (rst_n && fill_valid && fill_ready) begin
      check(!req_ready, "R9 ready during refill", {31'b0, req_ready}, 32'h0);
      check(wb_q.size() == 0, "R6 writeback before refill", wb_q.size(), 32'h0);
      if (fill_q.size() == 0) check(0, "R4 unexpected refill", fill_addr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        e = fill_q.pop_front();
        check(fill_addr == e, "R4 refill address", fill_addr, e);
      end
    end
  end

  // Responders with programmable latency
  initial begin
    int wc = 0, fc = 0;
    forever begin
      step();
      if (wb_ready) begin wb_ready = 0; wc = 0; end
      else if (wb_valid) begin if (wc >= wb_lat) wb_ready = 1; else wc++; end
      if (fill_ready) begin fill_ready = 0; fc = 0; end
      else if (fill_valid) begin if (fc >= fill_lat) fill_ready = 1; else fc++; end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(0, "R2 watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    for (int s = 0; s < 256; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = '0; end
    end
    repeat (3) step();
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready after reset", {31'b0, req_ready}, 32'h1);
    check(!res_valid && !wb_valid && !fill_valid, "R1 outputs idle after reset",
          {29'b0, res_valid, wb_valid, fill_valid}, 32'h0);
    rst_n = 1;
    step();
    check(req_ready == 1'b1, "R1 req_ready out of reset", {31'b0, req_ready}, 32'h1);
    // R1 R4 first lookup misses; R3 hit; R7 write hit dirties
    access(8'h41, 20'h12345, 0);
    access(8'h41, 20'h12345, 0);
    access(8'h41, 20'h12345, 1);
    // R5 R6 alias of dirty copy in another set
    access(8'hC1, 20'h12345, 0);
    // R5 alias back, clean copy, no writeback
    access(8'h41, 20'h12345, 0);
    // R8 LRU replacement and dirty victim writeback
    access(8'h02, 20'h0AAAA, 0);
    access(8'h02, 20'h0BBBB, 0);
    access(8'h02, 20'h0AAAA, 1);
    access(8'h02, 20'h0CCCC, 0);
    access(8'h02, 20'h0DDDD, 0);
    // R6 R8 alias dirty plus dirty victim in home set, with back-pressure (R9)
    wb_lat = 3; fill_lat = 4; xl_lat = 2;
    access(8'h82, 20'h0EEEE, 1);
    access(8'h82, 20'h0EEEE, 1);
    access(8'h82, 20'h0FFFF, 1);
    access(8'h82, 20'h0FFFF, 1);
    access(8'h02, 20'h0FFFF, 0);
    access(8'h02, 20'h0EEEE, 0);
    // Mixed traffic over a few aliasing sets
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x;
      x = nxt();
      wb_lat = x[1:0]; fill_lat = x[3:2]; xl_lat = x[5:4] == 2'b11 ? 1 : 0;
      access({x[7:6], 5'b0, x[8]}, {17'h00100, 1'b0, x[10:9]}, x[11]);
    end
    repeat (5) step();
    check(res_q.size() == 0 && wb_q.size() == 0 && fill_q.size() == 0, "R2 all expectations consumed",
          res_q.size() + wb_q.size() + fill_q.size(), 32'h0);
    finish_run();
  end
endmodule